// File: doc/BRIEF.md
# Array Summation Accelerator

This block adds up a run of consecutive words held in its own small data memory. The add loop is fixed in hardware: a controller state machine steps an index register through the elements, and a total register collects the sum. There is no program store and no instruction decoding. The only hardware is the index register, the total register, one adder and the data memory.

A host first fills the memory through a write port. It then gives a pulse on `start_i` with the element count on `len_i`. The block clears its total, walks the elements in ascending order and adds each one in. It then raises `done_o` and holds the sum on `sum_o` until the next start.

The memory read is synchronous, so each element takes two cycles: one cycle issues the read and the next cycle adds the fetched word.

Top module: `vsum_engine`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `sum_o` is 0.
- R2: A `start_i` pulse is accepted when the block is idle or done. It samples `len_i`. From the cycle after that edge, `busy_o` is 1 and `done_o` is 0.
- R3: The total is cleared before the first element is added. A result never contains a contribution from an earlier run.
- R4: Element k, for k from 1 to N, is the word at memory address k-1. Each element is added exactly once, in ascending order. `done_o` rises on the (1+2N)-th rising clock edge after the edge that accepted the start.
- R5: While the block is done, `done_o` stays 1 and `sum_o` stays unchanged until the next accepted start.
- R6: A count of zero finishes one edge after the start with a sum of zero.
- R7: The total is `DATA_W`+8 bits wide and wraps modulo 2 to the power of that width.
- R8: A host write is ignored while `busy_o` is 1. A host write is stored when the block is idle or done.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. It changes neither the count, the timing nor the result of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Assertion takes effect at once; release is synchronised inside the block. |
| start_i | input | 1 | Run request pulse |
| len_i | input | ADDR_W+1 | Element count N, sampled with an accepted start |
| wr_en_i | input | 1 | Host memory write enable |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has finished and the result is valid |
| sum_o | output | DATA_W+8 | Running total, final once `done_o` is 1 |

## Verification
The assertions take for granted that `len_i` never exceeds the memory depth when a start is accepted. They also take for granted that memory words are written before they are summed. One property states the first assumption on the inputs.

The stimulus preloads every address before the first run. It only asks for counts from 0 up to exactly the depth. It pokes writes and extra starts during a run only to show that they are rejected.

A behavioural model in the bench keeps its own copy of the memory and a countdown for each run. It is compared with the outputs on every cycle.

// File: rtl/vsum_pkg.sv
package vsum_pkg;
  localparam int ACC_GROW = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_READ = 3'd2,
    ST_ACC  = 3'd3,
    ST_DONE = 3'd4
  } vsum_state_e;
endpackage

// File: rtl/vsum_rst_sync.sv
module vsum_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vsum_mem.sv
module vsum_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // Write port: one word per cycle when enabled
  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  // Read port: registered output, one cycle of latency
  always_ff @(posedge clk) begin
    if (re) rdata_q <= cell_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/vsum_ctrl.sv
module vsum_ctrl
  import vsum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        len_zero,
  input  logic        at_last,
  output vsum_state_e state,
  output logic        ld_len,
  output logic        clr,
  output logic        rd_en,
  output logic        acc_en,
  output logic        inc_idx
);
  vsum_state_e st_q, st_d;

  // Next-state logic and datapath controls
  always_comb begin
    st_d    = st_q;
    ld_len  = 1'b0;
    clr     = 1'b0;
    rd_en   = 1'b0;
    acc_en  = 1'b0;
    inc_idx = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ld_len = 1'b1;
          st_d   = ST_INIT;
        end
      end
      ST_INIT: begin
        clr  = 1'b1;
        st_d = len_zero ? ST_DONE : ST_READ;
      end
      ST_READ: begin
        rd_en = 1'b1;
        st_d  = ST_ACC;
      end
      ST_ACC: begin
        acc_en = 1'b1;
        if (at_last) begin
          st_d = ST_DONE;
        end else begin
          inc_idx = 1'b1;
          st_d    = ST_READ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/vsum_dpath.sv
module vsum_dpath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  parameter int ACC_W  = DATA_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   len,
  input  logic              ld_len,
  input  logic              clr,
  input  logic              acc_en,
  input  logic              inc_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   idx,
  output logic [ADDR_W:0]   cnt,
  output logic              len_zero,
  output logic              at_last,
  output logic [ACC_W-1:0]  total
);
  localparam int IW = ADDR_W + 1;

  logic [IW-1:0]    cnt_q, idx_q, idx_m1;
  logic [ACC_W-1:0] total_q;

  // Element count, captured with an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld_len) cnt_q <= len;
  end

  // Index register, counts from 1 up to the element count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (clr)     idx_q <= IW'(1);
    else if (inc_idx) idx_q <= idx_q + IW'(1);
  end

  // Total register: cleared first, then one add per element
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total_q <= '0;
    else if (clr)    total_q <= '0;
    else if (acc_en) total_q <= total_q + ACC_W'(rdata);
  end

  assign idx_m1   = idx_q - IW'(1);
  assign raddr    = idx_m1[ADDR_W-1:0];
  assign at_last  = (idx_m1 == (cnt_q - IW'(1)));
  assign len_zero = (cnt_q == '0);
  assign idx      = idx_q;
  assign cnt      = cnt_q;
  assign total    = total_q;
endmodule

// File: rtl/vsum_engine.sv
module vsum_engine
  import vsum_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [ADDR_W:0]            len_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [DATA_W+ACC_GROW-1:0] sum_o
);
  localparam int ACC_W = DATA_W + ACC_GROW;
  localparam int DEPTH = 1 << ADDR_W;

  logic              rst_q;
  vsum_state_e       state;
  logic              ld_len, clr, rd_en, acc_en, inc_idx;
  logic              len_zero, at_last;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W:0]   idx, cnt;
  logic [DATA_W-1:0] rdata;
  logic              mem_we;

  vsum_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  vsum_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q),
    .start    (start_i),
    .len_zero (len_zero),
    .at_last  (at_last),
    .state    (state),
    .ld_len   (ld_len),
    .clr      (clr),
    .rd_en    (rd_en),
    .acc_en   (acc_en),
    .inc_idx  (inc_idx)
  );

  vsum_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_q),
    .len      (len_i),
    .ld_len   (ld_len),
    .clr      (clr),
    .acc_en   (acc_en),
    .inc_idx  (inc_idx),
    .rdata    (rdata),
    .raddr    (raddr),
    .idx      (idx),
    .cnt      (cnt),
    .len_zero (len_zero),
    .at_last  (at_last),
    .total    (sum_o)
  );

  // Host writes only land while no run is active
  assign mem_we = wr_en_i & ~busy_o;

  vsum_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (wr_addr_i),
    .wdata (wr_data_i),
    .re    (rd_en),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign busy_o = (state == ST_INIT) || (state == ST_READ) || (state == ST_ACC);
  assign done_o = (state == ST_DONE);

  // R3: the total is zero right after the clearing state
  a_r3_clear_first: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_INIT) |=> (sum_o == '0));

  // R4: an add only happens with the index inside 1..N
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_ACC) |-> ((idx >= 1) && (idx <= cnt)));

  // R4: the index climbs by one between adds
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_q)
    ((state == ST_READ) && ($past(state) == ST_ACC)) |-> (idx == $past(idx) + 1'b1));

  // R4: assumption on the inputs, the count stays within the memory depth
  a_r4_len_fits: assert property (@(posedge clk) disable iff (!rst_q)
    (start_i && !busy_o) |-> (int'(len_i) <= DEPTH));

  // R5: the result holds while done stays high
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (done_o && $past(done_o)) |-> $stable(sum_o));

  // R6: a zero count finishes right after clearing
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_q)
    ((state == ST_INIT) && (cnt == '0)) |=> done_o);

  // R9: a run, once begun, keeps its element count
  a_r9_cnt_kept: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && $past(busy_o)) |-> $stable(cnt));
endmodule

// File: tb/sim_vsum_engine.sv
module sim_vsum_engine;
  localparam int DW   = 8;
  localparam int AW   = 9;
  localparam int ACCW = DW + 8;
  localparam int DEP  = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [AW:0]     len_i = '0;
  logic            wr_en_i = 1'b0;
  logic [AW-1:0]   wr_addr_i = '0;
  logic [DW-1:0]   wr_data_i = '0;
  logic            busy_o, done_o;
  logic [ACCW-1:0] sum_o;

  always #4 clk = ~clk;

  vsum_engine #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o));

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: memory copy plus a countdown per run
  logic [DW-1:0] shadow [DEP];
  bit            m_busy = 1'b0, m_done = 1'b0;
  int            m_rem = 0;
  longint        m_sum = 0, m_pend = 0;

  function automatic longint ref_sum(input int n);
    longint s = 0;
    for (int k = 0; k < n; k++) s += longint'(shadow[k]);
    return s % (longint'(1) << ACCW);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_sum = 0; m_rem = 0;
    end else begin
      if (!m_busy && wr_en_i) shadow[wr_addr_i] = wr_data_i;
      if (!m_busy && start_i) begin
        m_pend = ref_sum(int'(len_i));
        m_rem  = 1 + 2 * int'(len_i);
        m_busy = 1'b1;
        m_done = 1'b0;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_sum = m_pend;
        end
      end
    end
  end

  // Per-cycle comparison against the model (R4 R5 R8 R9)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy_o == m_busy, "R4 busy vs model", busy_o, m_busy);
      chk(done_o == m_done, "R5 done vs model", done_o, m_done);
      if (!m_busy) chk(longint'(sum_o) == m_sum, "R5 sum vs model", sum_o, m_sum);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic host_wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = DW'(d);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 3000) begin
      step();
      lat++;
    end
  endtask

  task automatic run(input int n, output int lat);
    start_i = 1'b1; len_i = (AW+1)'(n);
    step();
    start_i = 1'b0;
    chk(busy_o && !done_o, "R2 busy after start", busy_o, 1);
    wait_done(lat);
  endtask

  int     lat;
  longint exp_v, held;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done at reset", done_o, 0);
    chk(sum_o == '0, "R1 sum at reset", sum_o, 0);

    for (int i = 0; i < DEP; i++) host_wr(i, (i * 37 + 11) & 255);

    exp_v = ref_sum(5);
    run(5, lat);
    chk(longint'(sum_o) == exp_v, "R4 sum of five", sum_o, exp_v);
    chk(lat == 2 + 2 * 5, "R4 latency of five", lat, 12);

    held = longint'(sum_o);
    repeat (8) step();
    chk(done_o && longint'(sum_o) == held, "R5 result held", sum_o, held);

    exp_v = ref_sum(3);
    run(3, lat);
    chk(longint'(sum_o) == exp_v, "R3 fresh total", sum_o, exp_v);

    run(0, lat);
    chk(sum_o == '0, "R6 zero count sum", sum_o, 0);
    chk(lat == 2, "R6 zero count latency", lat, 2);

    // R8 and R9: write and start during a run are rejected
    exp_v = ref_sum(6);
    start_i = 1'b1; len_i = (AW+1)'(6);
    step();
    start_i = 1'b0;
    step(); step();
    wr_en_i = 1'b1; wr_addr_i = AW'(2); wr_data_i = 8'd0;
    start_i = 1'b1; len_i = (AW+1)'(1);
    step();
    wr_en_i = 1'b0; start_i = 1'b0;
    wait_done(lat);
    chk(longint'(sum_o) == exp_v, "R9 restart ignored", sum_o, exp_v);
    exp_v = ref_sum(3);
    run(3, lat);
    chk(longint'(sum_o) == exp_v && exp_v == 11 + 48 + 85, "R8 busy write ignored", sum_o, 144);

    host_wr(2, 200);
    run(3, lat);
    chk(longint'(sum_o) == 11 + 48 + 200, "R8 write in done stored", sum_o, 259);

    for (int i = 0; i < DEP; i++) host_wr(i, 255);
    run(DEP, lat);
    chk(longint'(sum_o) == 65024, "R7 wrap at full depth", sum_o, 65024);
    chk(lat == 2 + 2 * DEP, "R4 latency at full depth", lat, 2 + 2 * DEP);

    step();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule